// File: doc/BRIEF.md
# Leading-Sign Exponent Detector

This block works out the shift code that normalizes a 16-bit twos-complement word, or a 32-bit value that arrives as two 16-bit words, high word first. It counts how many copies of the sign bit sit above the first significant bit. It stores the negative of the redundant part of that count in an 8-bit exponent register, which is read out sign-extended to 16 bits. Alongside the exponent it updates a flag that holds the sign of the input.

A word is accepted when `valid` and `cond_true` are both high. The `mode` input chooses how the word is read:

- **Single or high word.** A plain mode and an overflow-aware mode handle a single word or the high word of a pair. The overflow-aware mode is meant for the raw result of an adder whose overflow bit is supplied on `ovf_in`.
- **Low word.** This mode refines the exponent when the preceding high word held nothing but sign bits. To do that, the block remembers two things across the pair: whether the high word was all sign bits, and which sign it carried.

Results appear on the outputs in the clock cycle after the accepting edge.

Top module: `exp_detector`

## Requirements
- R1: Mode encoding is 2'b00 plain high, 2'b01 overflow-aware high, 2'b10 low word and 2'b11 reserved. In plain high mode the exponent becomes minus (number of leading bits equal to bit 15, minus one), which lies between -15 and 0.
- R2: In overflow-aware high mode with `ovf_in` = 0, the exponent and the sign flag are the same as in plain high mode.
- R3: In overflow-aware high mode with `ovf_in` = 1, the exponent becomes +1 and the sign flag becomes the inverse of bit 15.
- R4: In either high mode without overflow, the sign flag becomes bit 15 of the word.
- R5: A low-word pass never changes the sign flag. When the last high pass did not see an all-sign word, a low-word pass also leaves the exponent unchanged.
- R6: When the last high pass saw an all-sign word, a low-word pass writes -15 minus the number of leading low-word bits that equal the high word's sign. This gives -31 when all 32 bits match. The all-sign memory is consumed, so a second low pass changes nothing.
- R7: When `valid` is low or `cond_true` is low, neither the exponent nor the sign flag changes.
- R8: The reserved mode 2'b11 changes neither the exponent nor the sign flag.
- R9: After reset the exponent reads 0 and the sign flag reads 0.
- R10: `exp_out` is the 8-bit exponent sign-extended to 16 bits.
- R11: An accepted word is reflected on the outputs in the cycle after the clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid | input | 1 | Word strobe |
| cond_true | input | 1 | Condition outcome; the operation is performed only when this is high |
| mode | input | 2 | Pass mode: 00 high, 01 overflow-aware high, 10 low, 11 reserved |
| ovf_in | input | 1 | Overflow bit of the adder result, used in overflow-aware mode |
| word_in | input | 16 | Twos-complement input word |
| exp_out | output | 16 | Exponent register, sign-extended |
| sign_flag | output | 1 | Sign of the input |

## Verification
The assertions assume that `mode`, `ovf_in` and `word_in` are stable and known on every edge where `valid` is high. They also assume that a low-word pass belongs to the most recent high pass, so its range check on -31 to -15 only makes sense after such a pair. The bench changes inputs only on falling edges and holds the strobe for exactly one rising edge. It always issues a high pass before the low passes that are meant to refine it. Cases with a stale or spent all-sign memory are provoked on purpose, and their expected result is no change.

// File: rtl/exp_det_pkg.sv
package exp_det_pkg;
  typedef enum logic [1:0] {
    MODE_HI   = 2'b00,
    MODE_HIX  = 2'b01,
    MODE_LO   = 2'b10,
    MODE_RSVD = 2'b11
  } pass_mode_e;
endpackage

// File: rtl/exp_lead_count.sv
module exp_lead_count #(
  parameter int W     = 16,
  parameter int CNT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     word,
  input  logic             ref_bit,
  output logic [CNT_W-1:0] count,
  output logic             all_match
);
  // run[i] is high while every bit from W-1 down to i equals ref_bit
  logic [W:0] run;
  assign run[W] = 1'b1;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_run
      assign run[i] = run[i+1] & (word[i] == ref_bit);
    end
  endgenerate

  assign count     = CNT_W'($countones(run[W-1:0]));
  assign all_match = run[0];
endmodule

// File: rtl/exp_next_calc.sv
module exp_next_calc
  import exp_det_pkg::*;
#(
  parameter int W     = 16,
  parameter int EXP_W = 8,
  parameter int CNT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     word,
  input  pass_mode_e       mode,
  input  logic             ovf,
  input  logic [EXP_W-1:0] cur_exp,
  input  logic             cur_sign,
  input  logic             cur_all,
  input  logic             cur_hsign,
  output logic [EXP_W-1:0] nxt_exp,
  output logic             nxt_sign,
  output logic             nxt_all,
  output logic             nxt_hsign,
  output logic             ev_ovf,
  output logic             ev_refine
);
  logic [CNT_W-1:0] hi_cnt, lo_cnt;
  logic             hi_all, lo_all_unused;

  // High word: count bits equal to its own MSB (MSB included)
  exp_lead_count #(.W(W), .CNT_W(CNT_W)) u_hi_cnt (
    .word(word), .ref_bit(word[W-1]), .count(hi_cnt), .all_match(hi_all)
  );
  // Low word: count bits equal to the sign captured on the high pass
  exp_lead_count #(.W(W), .CNT_W(CNT_W)) u_lo_cnt (
    .word(word), .ref_bit(cur_hsign), .count(lo_cnt), .all_match(lo_all_unused)
  );

  // Negated redundant-sign count of a single word: 1 - leading
  function automatic logic [EXP_W-1:0] hi_code(input logic [CNT_W-1:0] lead);
    return EXP_W'(1) - EXP_W'(lead);
  endfunction

  // Refined code for the low word: -(W-1) - leading
  function automatic logic [EXP_W-1:0] lo_code(input logic [CNT_W-1:0] lead);
    return EXP_W'(0) - EXP_W'(W - 1) - EXP_W'(lead);
  endfunction

  assign ev_ovf    = (mode == MODE_HIX) && ovf;
  assign ev_refine = (mode == MODE_LO) && cur_all;

  always_comb begin
    nxt_exp   = cur_exp;
    nxt_sign  = cur_sign;
    nxt_all   = cur_all;
    nxt_hsign = cur_hsign;
    unique case (mode)
      MODE_HI, MODE_HIX: begin
        if (ev_ovf) begin
          nxt_exp   = EXP_W'(1);
          nxt_sign  = ~word[W-1];
          nxt_all   = 1'b0;
          nxt_hsign = ~word[W-1];
        end else begin
          nxt_exp   = hi_code(hi_cnt);
          nxt_sign  = word[W-1];
          nxt_all   = hi_all;
          nxt_hsign = word[W-1];
        end
      end
      MODE_LO: begin
        if (ev_refine) nxt_exp = lo_code(lo_cnt);
        nxt_all = 1'b0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/exp_detector.sv
module exp_detector
  import exp_det_pkg::*;
#(
  parameter int W     = 16,
  parameter int EXP_W = 8,
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic             cond_true,
  input  logic [1:0]       mode,
  input  logic             ovf_in,
  input  logic [W-1:0]     word_in,
  output logic [OUT_W-1:0] exp_out,
  output logic             sign_flag
);
  localparam int EXT_W = OUT_W - EXP_W;

  logic [EXP_W-1:0] exp_q, exp_d;
  logic             sign_q, sign_d, all_q, all_d, hsign_q, hsign_d;
  logic             fire, ev_ovf, ev_refine;
  pass_mode_e       mode_e;

  assign mode_e = pass_mode_e'(mode);
  assign fire   = valid && cond_true && (mode_e != MODE_RSVD);

  exp_next_calc #(.W(W), .EXP_W(EXP_W)) u_calc (
    .word(word_in), .mode(mode_e), .ovf(ovf_in),
    .cur_exp(exp_q), .cur_sign(sign_q), .cur_all(all_q), .cur_hsign(hsign_q),
    .nxt_exp(exp_d), .nxt_sign(sign_d), .nxt_all(all_d), .nxt_hsign(hsign_d),
    .ev_ovf(ev_ovf), .ev_refine(ev_refine)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q   <= '0;
      sign_q  <= 1'b0;
      all_q   <= 1'b0;
      hsign_q <= 1'b0;
    end else if (fire) begin
      exp_q   <= exp_d;
      sign_q  <= sign_d;
      all_q   <= all_d;
      hsign_q <= hsign_d;
    end
  end

  assign exp_out   = {{EXT_W{exp_q[EXP_W-1]}}, exp_q};
  assign sign_flag = sign_q;

  // R7: nothing moves without an accepted strobe
  assert_hold_no_cond_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid && cond_true) |=> $stable(exp_out) && $stable(sign_flag));
  // R8: reserved mode is inert
  assert_rsvd_inert_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && mode == 2'b11) |=> $stable(exp_out) && $stable(sign_flag));
  // R3: overflow-aware high pass gives +1
  assert_ovf_plus_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && cond_true && ev_ovf) |=> (exp_out == OUT_W'(1)));
  // R1: plain high pass stays in -15..0
  assert_hi_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && cond_true && mode == 2'b00) |=>
      ($signed(exp_out) <= 0) && ($signed(exp_out) >= -(W - 1)));
  // R5: low pass keeps the sign flag
  assert_lo_sign_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && cond_true && mode == 2'b10) |=> $stable(sign_flag));
  // R5: low pass without all-sign high word keeps the exponent
  assert_lo_no_refine_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && cond_true && mode == 2'b10 && !ev_refine) |=> $stable(exp_out));
  // R6: refined exponent lies in -31..-15
  assert_lo_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && cond_true && ev_refine) |=>
      ($signed(exp_out) <= -(W - 1)) && ($signed(exp_out) >= -(2 * W - 1)));
endmodule

// File: tb/tb_exp_detector.sv
module tb_exp_detector;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic        cond_true = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        ovf_in = 1'b0;
  logic [15:0] word_in = '0;
  logic [15:0] exp_out;
  logic        sign_flag;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;  // 250 MHz

  exp_detector dut (
    .clk(clk), .rst_n(rst_n), .valid(valid), .cond_true(cond_true),
    .mode(mode), .ovf_in(ovf_in), .word_in(word_in),
    .exp_out(exp_out), .sign_flag(sign_flag)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one strobe; returns at the falling edge after the accepting edge
  task automatic issue(input logic [1:0] m, input logic [15:0] w, input logic ov, input logic c, input logic v);
    @(negedge clk);
    mode = m; word_in = w; ovf_in = ov; cond_true = c; valid = v;
    @(negedge clk);
    valid = 1'b0; cond_true = 1'b0;
  endtask

  function automatic logic [15:0] sx(input int v);
    return 16'(v);
  endfunction

  task automatic t_reset();
    chk("R9 exp after reset", exp_out, 16'h0000);
    chk("R9 sign after reset", {15'b0, sign_flag}, 16'h0000);
  endtask

  task automatic t_hi();
    issue(2'b00, 16'hF6D4, 0, 1, 1);          // four leading ones
    chk("R1 R11 hi F6D4", exp_out, sx(-3));
    chk("R4 sign F6D4", {15'b0, sign_flag}, 16'h0001);
    chk("R10 upper bits extended", {8'b0, exp_out[15:8]}, 16'h00FF);
    issue(2'b00, 16'h4000, 0, 1, 1);
    chk("R1 hi 4000", exp_out, sx(0));
    chk("R4 sign 4000", {15'b0, sign_flag}, 16'h0000);
    issue(2'b00, 16'h0001, 0, 1, 1);
    chk("R1 hi 0001", exp_out, sx(-14));
  endtask

  task automatic t_hix();
    issue(2'b01, 16'h0123, 0, 1, 1);          // seven leading zeros
    chk("R2 hix no ovf", exp_out, sx(-6));
    issue(2'b01, 16'h8000, 1, 1, 1);
    chk("R3 hix ovf exp", exp_out, sx(1));
    chk("R3 hix ovf sign", {15'b0, sign_flag}, 16'h0000);
    issue(2'b10, 16'h0000, 0, 1, 1);          // ovf pass left no all-sign memory
    chk("R5 lo after ovf", exp_out, sx(1));
  endtask

  task automatic t_lo();
    issue(2'b00, 16'hF6D4, 0, 1, 1);
    issue(2'b10, 16'h0000, 0, 1, 1);
    chk("R5 lo no refine exp", exp_out, sx(-3));
    chk("R5 lo keeps sign", {15'b0, sign_flag}, 16'h0001);
    issue(2'b00, 16'h0000, 0, 1, 1);
    chk("R1 all zero hi", exp_out, sx(-15));
    issue(2'b10, 16'h04A2, 0, 1, 1);          // five leading zeros
    chk("R6 lo refine 04A2", exp_out, sx(-20));
    issue(2'b10, 16'h0000, 0, 1, 1);
    chk("R6 memory consumed", exp_out, sx(-20));
    issue(2'b00, 16'hFFFF, 0, 1, 1);
    issue(2'b10, 16'hFFFF, 0, 1, 1);
    chk("R6 all 32 ones", exp_out, sx(-31));
    chk("R5 lo sign neg", {15'b0, sign_flag}, 16'h0001);
    issue(2'b00, 16'hFFFF, 0, 1, 1);
    issue(2'b10, 16'h7FFF, 0, 1, 1);
    chk("R6 lo no match", exp_out, sx(-15));
  endtask

  task automatic t_hold();
    issue(2'b00, 16'h0001, 0, 1, 1);
    issue(2'b00, 16'hC000, 0, 0, 1);
    chk("R7 cond false exp", exp_out, sx(-14));
    chk("R7 cond false sign", {15'b0, sign_flag}, 16'h0000);
    issue(2'b01, 16'h8000, 1, 1, 0);
    chk("R7 valid low", exp_out, sx(-14));
    issue(2'b11, 16'hC000, 0, 1, 1);
    chk("R8 reserved exp", exp_out, sx(-14));
    chk("R8 reserved sign", {15'b0, sign_flag}, 16'h0000);
  endtask

  initial begin : wdog
    repeat (5000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_hi();
    t_hix();
    t_lo();
    t_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule